// File: doc/BRIEF.md
# Serial Dot-Matrix Register Interface

This block is the device-side register logic of a serially loaded LED dot-matrix driver. A host loads it over four pins: a serial clock, an active-low chip enable, a register select and a data input. The select pin is captured as chip enable falls. It chooses between a 160-bit dot shift register and an 8-bit control shift register. Bits shift in on rising serial clock edges while chip enable is low. When chip enable is high and the serial clock is low, the loaded contents move into a parallel dot latch or into one of two 7-bit control words. The LEDs therefore keep showing the old picture while a new one is being shifted in.

A serial data output lets two devices form a 320-bit chain. In serial mode it presents the last stage of the selected shift register. In simultaneous mode it repeats the data input combinationally while control data is being loaded, so that one control load reaches every device in the chain. The whole block runs on one system clock, and the four host pins are sampled as synchronous inputs.

Top module: `dotmatrix_serial_if`

## Requirements
- R1: While reset is asserted, and directly after it, both control words read zero and every LED output is zero.
- R2: The register select is taken only on a falling chip enable: low picks the dot register, high picks the control register. Changing the select while chip enable stays low has no effect.
- R3: While chip enable is low, each rising serial clock edge shifts the data input into bit 0 of the selected register. After 160 shifts, the first bit sent sits at LED index 159 and the last bit sent at LED index 0. A one turns its LED on.
- R4: The dot latch, and so the LED outputs, changes only in a cycle where chip enable is high and the serial clock is low. A partly loaded dot register is never shown.
- R5: Control data is sent most significant bit first. On transfer, bit 7 of the control shift register picks the destination (0 for word 0, 1 for word 1), and bits 6:0 are written into that word. The other word keeps its value.
- R6: Reset does not clear the dot register. A pattern loaded before a reset is shown again once the sleep bit is set after the reset, without reloading any dots.
- R7: In serial mode, the data output equals dot register bit 159 when the dot register is selected and control shift register bit 7 when the control register is selected. It is updated after every shift.
- R8: When bit 0 of control word 1 is high and the control register is selected, the data output follows the data input combinationally. When the dot register is selected, the output stays serial.
- R9: Bit 6 of control word 0 is the sleep bit. When it is low, all LED outputs are zero. When it is high, the LEDs equal the dot latch.
- R10: A rising serial clock edge while chip enable is high shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock |
| ce_n | input | 1 | Active-low chip enable |
| reg_sel | input | 1 | Register select: 0 dot, 1 control |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next device |
| led | output | 160 | LED on/off outputs |
| ctrl_word0 | output | 7 | Control word 0; bit 6 is the sleep bit |
| ctrl_word1 | output | 7 | Control word 1; bit 0 selects simultaneous mode |

## Verification
The assertions assume that every host pin is synchronous to the system clock and holds steady for at least one clock per level. A serial clock edge is therefore seen as one low sample followed by one high sample. The stimulus drives each pin on the falling system clock edge and holds every serial clock phase and chip-enable change for at least one full cycle. It never changes the select pin in the cycle where chip enable falls, so the select value captured on the falling edge is well defined.

// File: rtl/dotmatrix_serial_if.sv
module dotmatrix_serial_if #(
  parameter int N_DOTS = 160,
  parameter int CW_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ce_n,
  input  logic              reg_sel,
  input  logic              sdi,
  output logic              sdo,
  output logic [N_DOTS-1:0] led,
  output logic [CW_W-1:0]   ctrl_word0,
  output logic [CW_W-1:0]   ctrl_word1
);
  localparam int CSR_W     = CW_W + 1;
  localparam int SLEEP_BIT = CW_W - 1;
  localparam int MODE_BIT  = 0;

  logic              sclk_q, ce_q, sel_ctrl;
  logic [N_DOTS-1:0] dot_sr, dot_lat;
  logic [CSR_W-1:0]  csr;

  wire sclk_rise = sclk && !sclk_q;
  wire shift_en  = !ce_n && sclk_rise;
  wire xfer_en   = ce_n && !sclk;
  wire simul     = ctrl_word1[MODE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b1;
      ce_q       <= 1'b1;
      sel_ctrl   <= 1'b0;
      csr        <= '0;
      ctrl_word0 <= '0;
      ctrl_word1 <= '0;
    end else begin
      sclk_q <= sclk;
      ce_q   <= ce_n;
      if (ce_q && !ce_n) sel_ctrl <= reg_sel;
      if (shift_en && sel_ctrl) csr <= {csr[CSR_W-2:0], sdi};
      if (xfer_en && sel_ctrl) begin
        if (csr[CSR_W-1]) ctrl_word1 <= csr[CW_W-1:0];
        else              ctrl_word0 <= csr[CW_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en && !sel_ctrl) dot_sr <= {dot_sr[N_DOTS-2:0], sdi};
    if (xfer_en && !sel_ctrl)  dot_lat <= dot_sr;
  end

  assign led = dot_lat & {N_DOTS{ctrl_word0[SLEEP_BIT]}};
  assign sdo = sel_ctrl ? (simul ? sdi : csr[CSR_W-1]) : dot_sr[N_DOTS-1];

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_word0 == '0 && ctrl_word1 == '0));

  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> $stable(sel_ctrl));

  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n || sclk) |=> $stable(dot_lat));

  a_r5_word0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && sel_ctrl && csr[CSR_W-1]) |=> $stable(ctrl_word0));

  a_r5_word1_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && sel_ctrl && !csr[CSR_W-1]) |=> $stable(ctrl_word1));

  a_r10_no_shift_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(dot_sr) && $stable(csr)));

  always_comb begin
    if (!ctrl_word0[SLEEP_BIT]) a_r9_sleep_blank: assert (led == '0);
    if (sel_ctrl && simul) a_r8_passthru: assert (sdo == sdi);
  end
endmodule

// File: tb/dotmatrix_serial_if_tb_top.sv
module dotmatrix_serial_if_tb_top;
  localparam int N = 160;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, ce_n = 1'b1, reg_sel = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [N-1:0] led;
  logic [6:0] cw0, cw1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dotmatrix_serial_if dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ce_n(ce_n),
    .reg_sel(reg_sel), .sdi(sdi), .sdo(sdo), .led(led),
    .ctrl_word0(cw0), .ctrl_word1(cw1));

  // {control byte, expected word0, expected word1}
  localparam logic [21:0] TBL [6] = '{
    {8'h45, 7'h45, 7'h00},
    {8'h92, 7'h45, 7'h12},
    {8'h7F, 7'h7F, 7'h12},
    {8'h80, 7'h7F, 7'h00},
    {8'h2A, 7'h2A, 7'h00},
    {8'hC0, 7'h2A, 7'h40}
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_xfer(logic rs);
    ce_n = 1'b1; sclk = 1'b0; reg_sel = rs; step();
    ce_n = 1'b0; step();
  endtask

  task automatic shift_bit(logic b);
    sclk = 1'b0; sdi = b; step();
    sclk = 1'b1; step();
  endtask

  task automatic end_xfer();
    ce_n = 1'b1; step();
    sclk = 1'b0; step();
  endtask

  task automatic load_dots(logic [N-1:0] v);
    begin_xfer(1'b0);
    for (int i = N - 1; i >= 0; i--) shift_bit(v[i]);
    end_xfer();
  endtask

  task automatic load_ctrl(logic [7:0] c);
    begin_xfer(1'b1);
    for (int i = 7; i >= 0; i--) shift_bit(c[i]);
    end_xfer();
  endtask

  function automatic logic [N-1:0] pat(int k);
    logic [31:0] w = 32'hA5C3_0F01 ^ (32'h1111_2222 * k);
    return {w, ~w, w ^ 32'h0F0F_F0F0, {w[15:0], w[31:16]}, w + 32'd7};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] p1, p2;
    p1 = pat(1); p2 = pat(2);
    step(); step();
    chk("R1 word0 in reset", N'(cw0), '0);
    chk("R1 word1 in reset", N'(cw1), '0);
    chk("R1 leds in reset", led, '0);
    rst_n = 1'b1; step();
    chk("R1 word0 after reset", N'(cw0), '0);

    // R5: control table
    for (int t = 0; t < 6; t++) begin
      load_ctrl(TBL[t][21:14]);
      chk("R5 word0", N'(cw0), N'(TBL[t][13:7]));
      chk("R5 word1", N'(cw1), N'(TBL[t][6:0]));
      chk("R7 ctrl sdo", N'(sdo), N'(TBL[t][21]));
    end

    load_ctrl(8'h40);
    load_dots(p1);
    chk("R3 pattern shown", led, p1);
    chk("R7 dot sdo", N'(sdo), N'(p1[N-1]));

    // R4: partial load keeps old picture
    begin_xfer(1'b0);
    shift_bit(p2[N-1]);
    chk("R7 overflow bit", N'(sdo), N'(p1[N-2]));
    for (int i = N - 2; i >= 80; i--) shift_bit(p2[i]);
    chk("R4 old shown mid-load", led, p1);
    for (int i = 79; i >= 0; i--) shift_bit(p2[i]);
    ce_n = 1'b1; step();
    chk("R4 hold while clock high", led, p1);
    sclk = 1'b0; step();
    chk("R4 new pattern latched", led, p2);

    // R10: clock pulses with chip enable high
    sdi = 1'b1;
    for (int i = 0; i < 3; i++) begin sclk = 1'b1; step(); sclk = 1'b0; step(); end
    chk("R10 no shift when disabled", led, p2);

    // R2: select changed while enabled is ignored
    begin_xfer(1'b0);
    reg_sel = 1'b1;
    for (int i = N - 1; i >= 0; i--) shift_bit(p1[i]);
    end_xfer();
    chk("R2 dot still selected", led, p1);
    chk("R2 words untouched", N'(cw0), N'(7'h40));

    // R9: sleep gating
    load_ctrl(8'h00);
    chk("R9 sleep blanks", led, '0);
    load_ctrl(8'h40);
    chk("R9 wake shows latch", led, p1);

    // R8: simultaneous mode
    load_ctrl(8'h81);
    chk("R8 mode set", N'(cw1), N'(7'h01));
    begin_xfer(1'b1);
    sdi = 1'b1; #1;
    chk("R8 pass high", N'(sdo), N'(1'b1));
    sdi = 1'b0; #1;
    chk("R8 pass low", N'(sdo), N'(1'b0));
    for (int i = 7; i >= 0; i--) shift_bit(i == 7);
    end_xfer();
    chk("R8 word1 loaded in simul", N'(cw1), '0);
    begin_xfer(1'b0);
    sdi = ~p1[N-1]; #1;
    chk("R8 dot path stays serial", N'(sdo), N'(p1[N-1]));
    end_xfer();

    // R6: dots survive reset
    rst_n = 1'b0; step();
    chk("R1 reset blanks", led, '0);
    chk("R1 reset word0", N'(cw0), '0);
    rst_n = 1'b1; step();
    load_ctrl(8'h40);
    chk("R6 dots kept across reset", led, p1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule